// File: doc/BRIEF.md
# Quadrature and Pulse-Count Input Decoder

This block sits between incremental position sensors and a position counter. It samples three sensor pins on the system clock and turns them into a one-cycle count strobe with a direction bit. One pin pair is read either as two quadrature signals in phase offset or as a dedicated up-pulse line and a dedicated down-pulse line. A third pin carries the index mark, which can request that the counter be cleared. A host loads a small configuration word that sets the count resolution, how the index is used and how the clear is timed. The design also watches the quadrature pair for transitions that no real sensor can produce and latches an error flag when one appears.

The outputs are plain pulses and levels, not a stream. The sensor cannot be stalled, so the counter must accept `cnt_stb` in the cycle it is high. There is no valid/ready handshake and no back-pressure. The sensor signals are assumed to be far slower than the clock. In quadrature format each pin may change at most once every four clocks. In pulse format each pin may toggle at up to half the clock rate.

Top module: `enc_front_decode`

## Requirements
- R1: With `fmt_updown`=0, the pins `enc_a`/`enc_b` are decoded as a quadrature pair. With `fmt_updown`=1, a rising edge on `enc_a` counts up and a rising edge on `enc_b` counts down. Rising edges on both pins in the same sample cancel and give no strobe.
- R2: A count from a pin change made before clock edge k appears as `cnt_stb` high for exactly one cycle after edge k+SYNC_STAGES (edge k+2 at the default of two synchronizer stages). A synchronous clear has the same latency.
- R3: In quadrature format, with the pair written as {A,B}, the order 00→10→11→01→00 moves forward and counts up. The reverse order counts down.
- R4: `cfg_res` selects the quadrature resolution. 00 counts only an A rise while moving forward and an A fall while moving backward. 01 counts every A transition. 10 and 11 count every legal transition of either pin. The field has no effect in pulse format.
- R5: `dir_invert`=1 inverts the reported direction of every count.
- R6: `cnt_up` reports the direction of the most recent count and holds that value between counts.
- R7: In quadrature format, a sample in which both A and B change gives no count. It sets `err_flag`, which then stays high until the next `cfg_wr`. Pulse format never sets the flag.
- R8: `cfg_idx` is applied on `cfg_wr`. 00 keeps the current index mode, 01 disables the index, 10 arms it for one occurrence, and 11 arms it for every occurrence. An index armed once returns to disabled after the first index that triggers a clear.
- R9: With `cfg_sync_clr`=0 and the index armed, `clr_async` follows the `enc_z` pin level with no clock delay, and `clr_sync` stays low.
- R10: With `cfg_sync_clr`=1 and the index armed, a qualifying index edge produces a one-cycle `clr_sync` pulse, and `clr_async` stays low.
- R11: With `cfg_fixed_edge`=1, the synchronous clear fires on the index rising edge. With 0, it fires on the rising edge while `cnt_up`=1 and on the falling edge while `cnt_up`=0.
- R12: After reset the block uses quad resolution, a disabled index, asynchronous clear and fixed edge. It also starts with `cnt_stb`=0, `cnt_up`=1, `err_flag`=0 and both clear outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_updown | input | 1 | 0: quadrature pair, 1: separate up/down pulses |
| dir_invert | input | 1 | Invert reported count direction |
| enc_a | input | 1 | Quadrature A or up-pulse pin |
| enc_b | input | 1 | Quadrature B or down-pulse pin |
| enc_z | input | 1 | Index pin |
| cfg_wr | input | 1 | Load configuration fields, clear error flag |
| cfg_res | input | 2 | Resolution field |
| cfg_idx | input | 2 | Index command field |
| cfg_sync_clr | input | 1 | 1: clocked clear, 0: direct clear |
| cfg_fixed_edge | input | 1 | 1: rising-edge clear, 0: direction-dependent edge |
| cnt_stb | output | 1 | One-cycle count strobe |
| cnt_up | output | 1 | Direction of latest count, 1 = up |
| clr_async | output | 1 | Unclocked clear request |
| clr_sync | output | 1 | One-cycle clocked clear request |
| err_flag | output | 1 | Sticky illegal-transition flag |

## Verification
The embedded assertions check on every cycle that a strobe is traced back to a sampled pin change and that a double change in quadrature format never counts. They also check that the direction and error flags hold their state, and that a one-shot index returns to disabled after firing. Only the bench scenarios can show the decode tables. The bench sweeps every ordered pair of quadrature states for each resolution and inversion setting. It also exercises pulse format, the index commands and both clear timings and edge choices, comparing against values derived from the state ordering.

// File: rtl/enc_front_pkg.sv
package enc_front_pkg;

  typedef enum logic [1:0] {
    IDX_OFF  = 2'd0,
    IDX_ONCE = 2'd1,
    IDX_ALL  = 2'd2
  } idx_mode_t;

  localparam logic [1:0] IDXCMD_KEEP = 2'b00;
  localparam logic [1:0] IDXCMD_OFF  = 2'b01;
  localparam logic [1:0] IDXCMD_ONCE = 2'b10;
  localparam logic [1:0] IDXCMD_ALL  = 2'b11;

  localparam logic [1:0] RES_DEFAULT = 2'b10;

  typedef struct packed {
    logic [1:0] res;
    logic       sync_clr;
    logic       fixed_edge;
  } cfg_t;

  function automatic logic res_is_quad(input logic [1:0] r);
    return r[1];
  endfunction

  function automatic logic res_is_double(input logic [1:0] r);
    return (r == 2'b01);
  endfunction

endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[DEPTH-2:0], din};
  end

  assign cur  = pipe[STAGES-1];
  assign prev = pipe[STAGES];

endmodule

// File: rtl/enc_cfg_regs.sv
module enc_cfg_regs
  import enc_front_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] res_in,
  input  logic [1:0] idx_cmd,
  input  logic       sync_in,
  input  logic       fixed_in,
  input  logic       disarm,
  output cfg_t       cfg,
  output idx_mode_t  idx_mode
);
  logic cmd_sets_mode;
  assign cmd_sets_mode = wr && (idx_cmd != IDXCMD_KEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.res        <= RES_DEFAULT;
      cfg.sync_clr   <= 1'b0;
      cfg.fixed_edge <= 1'b1;
    end else if (wr) begin
      cfg.res        <= res_in;
      cfg.sync_clr   <= sync_in;
      cfg.fixed_edge <= fixed_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_mode <= IDX_OFF;
    end else if (cmd_sets_mode) begin
      case (idx_cmd)
        IDXCMD_OFF:  idx_mode <= IDX_OFF;
        IDXCMD_ONCE: idx_mode <= IDX_ONCE;
        default:     idx_mode <= IDX_ALL;
      endcase
    end else if (disarm) begin
      idx_mode <= IDX_OFF;
    end
  end

  // R8
  once_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_mode == IDX_ONCE && disarm && !cmd_sets_mode) |=> (idx_mode == IDX_OFF));

  // R8
  keep_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx_cmd == IDXCMD_KEEP && !disarm) |=> $stable(idx_mode));

endmodule

// File: rtl/enc_count_decode.sv
module enc_count_decode
  import enc_front_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fmt_ud,
  input  logic       dir_inv,
  input  logic [1:0] res,
  input  logic       a_cur,
  input  logic       a_prev,
  input  logic       b_cur,
  input  logic       b_prev,
  input  logic       err_clr,
  output logic       cnt_stb,
  output logic       cnt_up,
  output logic       err_flag
);
  logic chg_a, chg_b;
  logic ab_legal, ab_clash, ab_fwd, ab_hit;
  logic ud_up, ud_dn;
  logic hit, raw_fwd;

  assign chg_a    = a_cur ^ a_prev;
  assign chg_b    = b_cur ^ b_prev;
  assign ab_legal = chg_a ^ chg_b;
  assign ab_clash = chg_a & chg_b;
  assign ab_fwd   = a_cur ^ b_prev;

  always_comb begin
    if (res_is_quad(res))        ab_hit = ab_legal;
    else if (res_is_double(res)) ab_hit = chg_a & ~chg_b;
    else                         ab_hit = chg_a & ~chg_b & (a_cur == ab_fwd);
  end

  assign ud_up   = a_cur & ~a_prev;
  assign ud_dn   = b_cur & ~b_prev;
  assign hit     = fmt_ud ? (ud_up ^ ud_dn) : ab_hit;
  assign raw_fwd = fmt_ud ? ud_up : ab_fwd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_stb <= 1'b0;
      cnt_up  <= 1'b1;
    end else begin
      cnt_stb <= hit;
      if (hit) cnt_up <= raw_fwd ^ dir_inv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  err_flag <= 1'b0;
    else if (!fmt_ud && ab_clash) err_flag <= 1'b1;
    else if (err_clr)            err_flag <= 1'b0;
  end

  // R2
  stb_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_stb |-> $past(chg_a | chg_b));

  // R7
  clash_nocount_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fmt_ud && ab_clash) |=> (!cnt_stb && err_flag));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  // R6
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_stb |-> $stable(cnt_up));

endmodule

// File: rtl/enc_index_ctrl.sv
module enc_index_ctrl
  import enc_front_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      z_raw,
  input  logic      z_cur,
  input  logic      z_prev,
  input  idx_mode_t idx_mode,
  input  logic      sync_clr,
  input  logic      fixed_edge,
  input  logic      cnt_up,
  output logic      clr_async,
  output logic      clr_sync,
  output logic      disarm
);
  logic armed, z_rise, z_fall, qual_edge, trig;

  assign armed  = (idx_mode != IDX_OFF);
  assign z_rise = z_cur & ~z_prev;
  assign z_fall = ~z_cur & z_prev;

  always_comb begin
    if (fixed_edge) qual_edge = z_rise;
    else if (cnt_up) qual_edge = z_rise;
    else            qual_edge = z_fall;
  end

  assign trig      = sync_clr ? qual_edge : z_rise;
  assign disarm    = (idx_mode == IDX_ONCE) && trig;
  assign clr_async = armed & ~sync_clr & z_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_sync <= 1'b0;
    else        clr_sync <= armed & sync_clr & qual_edge;
  end

  // R10
  sync_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sync |-> $past(z_cur != z_prev));

  // R11
  fixed_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sync && $past(fixed_edge)) |-> $past(z_cur));

endmodule

// File: rtl/enc_front_decode.sv
module enc_front_decode
  import enc_front_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fmt_updown,
  input  logic       dir_invert,
  input  logic       enc_a,
  input  logic       enc_b,
  input  logic       enc_z,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_res,
  input  logic [1:0] cfg_idx,
  input  logic       cfg_sync_clr,
  input  logic       cfg_fixed_edge,
  output logic       cnt_stb,
  output logic       cnt_up,
  output logic       clr_async,
  output logic       clr_sync,
  output logic       err_flag
);
  localparam int PIN_W = 3;
  localparam int PIN_A = 0;
  localparam int PIN_B = 1;
  localparam int PIN_Z = 2;

  logic [PIN_W-1:0] pins_cur, pins_prev;
  cfg_t             cfg;
  idx_mode_t        idx_mode;
  logic             disarm;

  enc_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({enc_z, enc_b, enc_a}),
    .cur  (pins_cur),
    .prev (pins_prev)
  );

  enc_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .res_in  (cfg_res),
    .idx_cmd (cfg_idx),
    .sync_in (cfg_sync_clr),
    .fixed_in(cfg_fixed_edge),
    .disarm  (disarm),
    .cfg     (cfg),
    .idx_mode(idx_mode)
  );

  enc_count_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .fmt_ud  (fmt_updown),
    .dir_inv (dir_invert),
    .res     (cfg.res),
    .a_cur   (pins_cur[PIN_A]),
    .a_prev  (pins_prev[PIN_A]),
    .b_cur   (pins_cur[PIN_B]),
    .b_prev  (pins_prev[PIN_B]),
    .err_clr (cfg_wr),
    .cnt_stb (cnt_stb),
    .cnt_up  (cnt_up),
    .err_flag(err_flag)
  );

  enc_index_ctrl u_idx (
    .clk       (clk),
    .rst_n     (rst_n),
    .z_raw     (enc_z),
    .z_cur     (pins_cur[PIN_Z]),
    .z_prev    (pins_prev[PIN_Z]),
    .idx_mode  (idx_mode),
    .sync_clr  (cfg.sync_clr),
    .fixed_edge(cfg.fixed_edge),
    .cnt_up    (cnt_up),
    .clr_async (clr_async),
    .clr_sync  (clr_sync),
    .disarm    (disarm)
  );

endmodule

// File: tb/enc_front_decode_tb.sv
module enc_front_decode_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fmt_updown = 1'b0, dir_invert = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0;
  logic cfg_wr = 1'b0, cfg_sync_clr = 1'b0, cfg_fixed_edge = 1'b1;
  logic [1:0] cfg_res = 2'b10, cfg_idx = 2'b00;
  logic cnt_stb, cnt_up, clr_async, clr_sync, err_flag;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  enc_front_decode u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_updown(fmt_updown), .dir_invert(dir_invert),
    .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z), .cfg_wr(cfg_wr),
    .cfg_res(cfg_res), .cfg_idx(cfg_idx), .cfg_sync_clr(cfg_sync_clr),
    .cfg_fixed_edge(cfg_fixed_edge), .cnt_stb(cnt_stb), .cnt_up(cnt_up),
    .clr_async(clr_async), .clr_sync(clr_sync), .err_flag(err_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gpos(input logic [1:0] ab);
    case (ab)
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  task automatic cfg_write(input logic [1:0] res, input logic [1:0] idx,
                           input logic sync, input logic fixed);
    @(negedge clk);
    cfg_res = res; cfg_idx = idx; cfg_sync_clr = sync; cfg_fixed_edge = fixed;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_ab(input logic [1:0] ab);
    @(negedge clk);
    enc_a = ab[1]; enc_b = ab[0];
  endtask

  task automatic set_z(input logic z);
    @(negedge clk);
    enc_z = z;
    #1;
  endtask

  task automatic to_output;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic settle;
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic zedge_sync(input logic z, input int exp, input string req);
    set_z(z);
    chk({req, " clr_async low in clocked mode"}, clr_async, 0);
    repeat (3) @(posedge clk);
    #1;
    chk({req, " clr_sync on index edge"}, clr_sync, exp);
    @(posedge clk); #1;
    chk({req, " clr_sync one cycle"}, clr_sync, 0);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R12 reset state
    chk("R12 cnt_stb", cnt_stb, 0);
    chk("R12 cnt_up", cnt_up, 1);
    chk("R12 err_flag", err_flag, 0);
    chk("R12 clr_async", clr_async, 0);
    chk("R12 clr_sync", clr_sync, 0);

    // R12 default quad: 00 -> 01 is one step backward and counts
    set_ab(2'b01);
    to_output();
    chk("R12 default quad stb", cnt_stb, 1);
    chk("R12 default quad dir", cnt_up, 0);
    settle();
    // R12 default index disabled
    set_z(1'b1);
    chk("R12 index off clr_async", clr_async, 0);
    settle();
    set_z(1'b0);
    set_ab(2'b00);
    settle();

    // R3 R4 R5 R6 R7 sweep of every ordered state pair
    for (int res = 0; res < 4; res++) begin
      for (int inv = 0; inv < 2; inv++) begin
        dir_invert = inv[0];
        cfg_write(res[1:0], 2'b00, 1'b0, 1'b1);
        for (int p = 0; p < 4; p++) begin
          for (int c = 0; c < 4; c++) begin
            if (p != c) begin
              logic [1:0] pv, cv;
              int d; bit illegal, up, achg, arise, hit, dir_before;
              pv = p[1:0]; cv = c[1:0];
              set_ab(pv);
              settle();
              cfg_write(res[1:0], 2'b00, 1'b0, 1'b1);
              #1;
              dir_before = cnt_up;
              d = (gpos(cv) - gpos(pv) + 4) % 4;
              illegal = (d == 2);
              up = (d == 1);
              achg = pv[1] ^ cv[1];
              arise = cv[1] & ~pv[1];
              if (illegal) hit = 0;
              else if (res >= 2) hit = 1;
              else if (res == 1) hit = achg;
              else hit = achg && (arise == up);
              set_ab(cv);
              to_output();
              chk("R4 R3 strobe per resolution", cnt_stb, int'(hit));
              if (hit) chk("R3 R5 direction", cnt_up, int'(up ^ inv[0]));
              else     chk("R6 direction held", cnt_up, int'(dir_before));
              chk("R7 illegal flag", err_flag, int'(illegal));
              @(posedge clk); #1;
              chk("R2 strobe one cycle", cnt_stb, 0);
              if (illegal) begin
                repeat (3) @(posedge clk); #1;
                chk("R7 flag sticky", err_flag, 1);
              end
            end
          end
        end
      end
    end
    set_ab(2'b00);
    settle();
    cfg_write(2'b10, 2'b00, 1'b0, 1'b1);
    #1;
    chk("R7 flag cleared by write", err_flag, 0);

    // R1 pulse format; R4 resolution ignored there
    dir_invert = 1'b0;
    fmt_updown = 1'b1;
    cfg_write(2'b00, 2'b00, 1'b0, 1'b1);
    set_ab(2'b10);
    to_output();
    chk("R1 up pulse strobe", cnt_stb, 1);
    chk("R1 up pulse dir", cnt_up, 1);
    settle();
    set_ab(2'b00);
    to_output();
    chk("R1 up fall no strobe", cnt_stb, 0);
    settle();
    set_ab(2'b01);
    to_output();
    chk("R1 down pulse strobe", cnt_stb, 1);
    chk("R1 down pulse dir", cnt_up, 0);
    settle();
    set_ab(2'b00);
    settle();
    set_ab(2'b11);
    to_output();
    chk("R1 simultaneous pulses cancel", cnt_stb, 0);
    chk("R7 no flag in pulse format", err_flag, 0);
    settle();
    set_ab(2'b00);
    settle();
    dir_invert = 1'b1;
    set_ab(2'b10);
    to_output();
    chk("R5 inverted up pulse", cnt_up, 0);
    chk("R5 inverted up pulse strobe", cnt_stb, 1);
    settle();
    set_ab(2'b00);
    settle();
    dir_invert = 1'b0;
    fmt_updown = 1'b0;
    settle();

    // R9 direct clear, every index
    cfg_write(2'b10, 2'b11, 1'b0, 1'b1);
    set_z(1'b1);
    chk("R9 clr_async follows pin", clr_async, 1);
    repeat (4) @(posedge clk); #1;
    chk("R9 clr_sync low in direct mode", clr_sync, 0);
    chk("R9 clr_async held while pin high", clr_async, 1);
    set_z(1'b0);
    chk("R9 clr_async released", clr_async, 0);
    settle();

    // R8 one-shot index in direct mode
    cfg_write(2'b10, 2'b10, 1'b0, 1'b1);
    set_z(1'b1);
    chk("R8 one-shot first index", clr_async, 1);
    settle();
    set_z(1'b0);
    settle();
    set_z(1'b1);
    chk("R8 one-shot disarmed", clr_async, 0);
    settle();
    set_z(1'b0);
    settle();

    // R10 R11 clocked clear, fixed edge, every index
    cfg_write(2'b10, 2'b11, 1'b1, 1'b1);
    zedge_sync(1'b1, 1, "R10 R11 fixed rise");
    zedge_sync(1'b0, 0, "R11 fixed fall ignored");

    // R11 variable edge, moving up
    set_ab(2'b10);
    settle();
    chk("R11 setup direction up", cnt_up, 1);
    cfg_write(2'b10, 2'b11, 1'b1, 1'b0);
    zedge_sync(1'b1, 1, "R11 variable rise while up");
    zedge_sync(1'b0, 0, "R11 variable fall while up");
    // moving down
    set_ab(2'b00);
    settle();
    chk("R11 setup direction down", cnt_up, 0);
    zedge_sync(1'b1, 0, "R11 variable rise while down");
    zedge_sync(1'b0, 1, "R11 variable fall while down");

    // R8 one-shot in clocked mode, then keep and off commands
    cfg_write(2'b10, 2'b10, 1'b1, 1'b1);
    zedge_sync(1'b1, 1, "R8 clocked one-shot first");
    zedge_sync(1'b0, 0, "R8 clocked one-shot fall");
    zedge_sync(1'b1, 0, "R8 clocked one-shot disarmed");
    zedge_sync(1'b0, 0, "R8 clocked one-shot idle");
    cfg_write(2'b10, 2'b11, 1'b1, 1'b1);
    cfg_write(2'b10, 2'b00, 1'b1, 1'b1);
    zedge_sync(1'b1, 1, "R8 keep command first");
    zedge_sync(1'b0, 0, "R8 keep command fall");
    zedge_sync(1'b1, 1, "R8 keep command second");
    zedge_sync(1'b0, 0, "R8 keep command idle");
    cfg_write(2'b10, 2'b01, 1'b1, 1'b1);
    zedge_sync(1'b1, 0, "R8 off command");
    zedge_sync(1'b0, 0, "R8 off command idle");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule